// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift/Store Register

This block is a parameterised register, eight bits wide by default, that updates on every rising clock edge. A two-bit mode select picks one of four operations: hold, shift toward the high index, shift toward the low index, or parallel capture. An active-low clear empties the register on the next edge. The clear is synchronous and takes priority over every mode.

The parallel data port is shared in both directions on the pins. Here it is modelled as an input bus, an output bus and a single output-enable. The port drives the register contents only when both active-low output controls are low and the block is not capturing. In every other case the enable drops and the output bus reads zero, which stands for high impedance.

Two tap outputs always show the lowest and highest register bits, whatever the enables are. Several blocks can therefore be chained by wiring these taps to the serial inputs of a neighbour. Typical uses are push-down stacks, holding buffers and accumulators.

Top module: `bidir_shift_store`

## Requirements
- R1: `selMode` encodes the operation as follows: 2'b00 holds, 2'b01 shifts toward the high index, 2'b10 shifts toward the low index, and 2'b11 performs a parallel capture. Bit 0 is the low end.
- R2: When `clrN` is low at a rising edge, every register bit becomes 0 on that edge, whatever the value of `selMode`.
- R3: With `clrN` high and `selMode`=00, the register keeps its contents across the edge.
- R4: With `clrN` high and `selMode`=01, `serToLow` enters bit 0 and each bit i moves to bit i+1. The old top bit is dropped.
- R5: With `clrN` high and `selMode`=10, `serToHigh` enters the top bit and each bit i moves to bit i-1. The old bit 0 is dropped.
- R6: With `clrN` high and `selMode`=11, the value on `ioIn` is stored on the edge.
- R7: `ioOe` is combinationally high exactly when both bits of `oeCtlN` are 0 and `selMode` is not 11.
- R8: `ioOut` equals the register contents while `ioOe` is high, and reads all zeros while it is low.
- R9: `tapLow` and `tapHigh` always equal register bit 0 and the top bit, including while `ioOe` is low.
- R10: `ioIn` has no effect on the register in any mode other than parallel capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Synchronous clear, active low |
| selMode | input | 2 | Operation select |
| oeCtlN | input | NUM_OE (2) | Output controls, active low, all must be low to drive |
| serToLow | input | 1 | Serial bit entering bit 0 when shifting up |
| serToHigh | input | 1 | Serial bit entering the top bit when shifting down |
| ioIn | input | WIDTH (8) | Levels seen on the shared pins |
| ioOut | output | WIDTH (8) | Value driven onto the shared pins |
| ioOe | output | 1 | Pin driver enable |
| tapLow | output | 1 | Always-driven copy of bit 0 |
| tapHigh | output | 1 | Always-driven copy of the top bit |

## Verification
The bench builds the block with the default WIDTH of 8 and NUM_OE of 2. At that width a handful of shifts carries a pattern from one end to the other. This lets the directed phase show serial bits arriving at the far tap and old end bits falling off. Two output controls are enough to show that a single high control blocks the drivers. A long random phase then covers every combination of clear, mode, enables and serial inputs, including clear during capture and capture with the drivers requested.

// File: rtl/bidir_shift_store_pkg.sv
package bidir_shift_store_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } modeSel_t;

  typedef struct packed {
    logic clear;
    logic shiftUp;
    logic shiftDown;
    logic load;
    logic drive;
  } ctrlStrobes_t;

endpackage

// File: rtl/bidir_shift_store_ctrl.sv
module bidir_shift_store_ctrl
  import bidir_shift_store_pkg::*;
#(
  parameter int NUM_OE = 2
) (
  input  logic              clrN,
  input  logic [1:0]        selMode,
  input  logic [NUM_OE-1:0] oeCtlN,
  output ctrlStrobes_t      strobes
);

  modeSel_t mode;
  logic     allEnabled;

  assign mode       = modeSel_t'(selMode);
  assign allEnabled = ~(|oeCtlN);

  always_comb begin
    strobes = '0;
    // clear overrides every mode
    strobes.clear = ~clrN;
    if (clrN) begin
      unique case (mode)
        MODE_UP:   strobes.shiftUp   = 1'b1;
        MODE_DOWN: strobes.shiftDown = 1'b1;
        MODE_LOAD: strobes.load      = 1'b1;
        default:   ;
      endcase
    end
    // drivers are released while capturing from the pins
    strobes.drive = allEnabled && (mode != MODE_LOAD);
  end

endmodule

// File: rtl/bidir_shift_store_dp.sv
module bidir_shift_store_dp
  import bidir_shift_store_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  input  logic             serToLow,
  input  logic             serToHigh,
  input  logic [WIDTH-1:0] ioIn,
  output logic [WIDTH-1:0] regVal,
  output logic [WIDTH-1:0] ioOut,
  output logic             ioOe,
  output logic             tapLow,
  output logic             tapHigh
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextVal;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromBelow;
    logic fromAbove;

    if (i == 0) begin : g_lowEnd
      assign fromBelow = serToLow;
    end else begin : g_lowMid
      assign fromBelow = regVal[i-1];
    end

    if (i == TOP) begin : g_highEnd
      assign fromAbove = serToHigh;
    end else begin : g_highMid
      assign fromAbove = regVal[i+1];
    end

    always_comb begin
      if (strobes.clear)          nextVal[i] = 1'b0;
      else if (strobes.load)      nextVal[i] = ioIn[i];
      else if (strobes.shiftUp)   nextVal[i] = fromBelow;
      else if (strobes.shiftDown) nextVal[i] = fromAbove;
      else                        nextVal[i] = regVal[i];
    end
  end

  always_ff @(posedge clk) begin
    regVal <= nextVal;
  end

  assign ioOe    = strobes.drive;
  assign ioOut   = strobes.drive ? regVal : '0;
  assign tapLow  = regVal[0];
  assign tapHigh = regVal[TOP];

endmodule

// File: rtl/bidir_shift_store.sv
module bidir_shift_store
  import bidir_shift_store_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int NUM_OE = 2
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic [1:0]        selMode,
  input  logic [NUM_OE-1:0] oeCtlN,
  input  logic              serToLow,
  input  logic              serToHigh,
  input  logic [WIDTH-1:0]  ioIn,
  output logic [WIDTH-1:0]  ioOut,
  output logic              ioOe,
  output logic              tapLow,
  output logic              tapHigh
);

  ctrlStrobes_t     strobes;
  logic [WIDTH-1:0] regVal;

  bidir_shift_store_ctrl #(.NUM_OE(NUM_OE)) u_ctrl (
    .clrN    (clrN),
    .selMode (selMode),
    .oeCtlN  (oeCtlN),
    .strobes (strobes)
  );

  bidir_shift_store_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .serToLow  (serToLow),
    .serToHigh (serToHigh),
    .ioIn      (ioIn),
    .regVal    (regVal),
    .ioOut     (ioOut),
    .ioOe      (ioOe),
    .tapLow    (tapLow),
    .tapHigh   (tapHigh)
  );

endmodule

// File: rtl/bidir_shift_store_chk.sv
module bidir_shift_store_chk #(
  parameter int WIDTH  = 8,
  parameter int NUM_OE = 2
) (
  input logic              clk,
  input logic              clrN,
  input logic [1:0]        selMode,
  input logic [NUM_OE-1:0] oeCtlN,
  input logic              serToLow,
  input logic              serToHigh,
  input logic [WIDTH-1:0]  ioIn,
  input logic [WIDTH-1:0]  ioOut,
  input logic              ioOe,
  input logic              tapLow,
  input logic              tapHigh,
  input logic [WIDTH-1:0]  regVal
);

  // contents are unknown until the first clear edge
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clrN) armed <= 1'b1;
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (!armed)
    !clrN |=> (regVal == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!armed)
    (clrN && selMode == 2'b00) |=> $stable(regVal));

  p_shift_up_r4: assert property (@(posedge clk) disable iff (!armed)
    (clrN && selMode == 2'b01) |=>
      (regVal == {$past(regVal[WIDTH-2:0]), $past(serToLow)}));

  p_shift_down_r5: assert property (@(posedge clk) disable iff (!armed)
    (clrN && selMode == 2'b10) |=>
      (regVal == {$past(serToHigh), $past(regVal[WIDTH-1:1])}));

  p_load_r6: assert property (@(posedge clk) disable iff (!armed)
    (clrN && selMode == 2'b11) |=> (regVal == $past(ioIn)));

  p_load_release_r7: assert property (@(posedge clk) disable iff (!armed)
    (selMode == 2'b11) |-> !ioOe);

  p_drive_value_r8: assert property (@(posedge clk) disable iff (!armed)
    ioOe |-> (ioOut == regVal));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!armed)
    !ioOe |-> (ioOut == '0));

  p_taps_r9: assert property (@(posedge clk) disable iff (!armed)
    (tapLow == regVal[0]) && (tapHigh == regVal[WIDTH-1]));

endmodule

bind bidir_shift_store bidir_shift_store_chk #(.WIDTH(WIDTH), .NUM_OE(NUM_OE)) u_chk (
  .clk       (clk),
  .clrN      (clrN),
  .selMode   (selMode),
  .oeCtlN    (oeCtlN),
  .serToLow  (serToLow),
  .serToHigh (serToHigh),
  .ioIn      (ioIn),
  .ioOut     (ioOut),
  .ioOe      (ioOe),
  .tapLow    (tapLow),
  .tapHigh   (tapHigh),
  .regVal    (regVal)
);

// File: tb/bidir_shift_store_bench.sv
module bidir_shift_store_bench;

  localparam int W  = 8;
  localparam int NO = 2;

  logic          clk = 1'b0;
  logic          clrN = 1'b1;
  logic [1:0]    selMode = 2'b00;
  logic [NO-1:0] oeCtlN = '1;
  logic          serToLow = 1'b0;
  logic          serToHigh = 1'b0;
  logic [W-1:0]  ioIn = '0;
  logic [W-1:0]  ioOut;
  logic          ioOe;
  logic          tapLow;
  logic          tapHigh;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    logic [W-1:0] q;
    logic         oe;
    string        tag;
  } item_t;

  item_t        expQ[$];
  logic [W-1:0] refQ;

  always #4 clk = ~clk;

  bidir_shift_store #(.WIDTH(W), .NUM_OE(NO)) u_bidir_shift_store (
    .clk(clk), .clrN(clrN), .selMode(selMode), .oeCtlN(oeCtlN),
    .serToLow(serToLow), .serToHigh(serToHigh), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .tapLow(tapLow), .tapHigh(tapHigh)
  );

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input logic c, input logic [1:0] s, input logic [NO-1:0] g,
                      input logic sLo, input logic sHi, input logic [W-1:0] d,
                      input string tag);
    item_t it;
    logic [W-1:0] nxt;
    @(negedge clk);
    clrN = c; selMode = s; oeCtlN = g; serToLow = sLo; serToHigh = sHi; ioIn = d;
    if (!c)            nxt = '0;                        // R2
    else if (s == 2'b00) nxt = refQ;                    // R3
    else if (s == 2'b01) nxt = {refQ[W-2:0], sLo};      // R4
    else if (s == 2'b10) nxt = {sHi, refQ[W-1:1]};      // R5
    else               nxt = d;                         // R6
    refQ   = nxt;
    it.q   = nxt;
    it.oe  = (g == '0) && (s != 2'b11);                 // R7
    it.tag = tag;
    expQ.push_back(it);
  endtask

  function automatic string modeTag(input logic c, input logic [1:0] s);
    if (!c) return "R2";
    case (s)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // monitor: compares the outputs shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check({it.tag, "/R7"}, "ioOe", {{(W-1){1'b0}}, ioOe}, {{(W-1){1'b0}}, it.oe});
        check({it.tag, "/R8"}, "ioOut", ioOut, it.oe ? it.q : '0);
        check({it.tag, "/R9"}, "tapLow", {{(W-1){1'b0}}, tapLow}, {{(W-1){1'b0}}, it.q[0]});
        check({it.tag, "/R9"}, "tapHigh", {{(W-1){1'b0}}, tapHigh}, {{(W-1){1'b0}}, it.q[W-1]});
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    refQ = '0;
    // reset state through clear (R2), outputs enabled
    step(1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 8'hFF, "R2");
    // capture: drivers released during load (R6, R7)
    step(1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 8'hA5, "R6");
    step(1'b1, 2'b00, 2'b00, 1'b1, 1'b1, 8'h3C, "R3");
    // shift up with ioIn toggling, which must be ignored (R4, R10)
    step(1'b1, 2'b01, 2'b00, 1'b1, 1'b0, 8'hFF, "R4_R10");
    step(1'b1, 2'b10, 2'b00, 1'b1, 1'b0, 8'h00, "R5_R10");
    step(1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 8'h5A, "R3_R10");
    // clear wins over capture (R2)
    step(1'b0, 2'b11, 2'b00, 1'b1, 1'b1, 8'hFF, "R2");
    step(1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 8'h81, "R6");
    // drivers disabled: taps still follow the ends (R8, R9)
    step(1'b1, 2'b00, 2'b11, 1'b0, 1'b0, 8'h00, "R9");
    step(1'b1, 2'b00, 2'b01, 1'b0, 1'b0, 8'h00, "R7");
    step(1'b1, 2'b00, 2'b10, 1'b0, 1'b0, 8'h00, "R7");
    // walk a one from bit 0 to the top tap (R1, R4)
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 8'h00, "R2");
    step(1'b1, 2'b01, 2'b00, 1'b1, 1'b0, 8'h00, "R1_R4");
    for (int i = 0; i < W - 1; i++) step(1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 8'h00, "R1_R4");
    // and back down through the low tap (R5)
    for (int i = 0; i < W; i++) step(1'b1, 2'b10, 2'b01, 1'b0, 1'b1, 8'h00, "R5");
    // random phase over every mode, clear, enable and serial combination
    for (int i = 0; i < 2000; i++) begin
      logic c;
      logic [1:0] s;
      c = ($urandom_range(0, 9) != 0);
      s = 2'($urandom);
      step(c, s, NO'($urandom), 1'($urandom), 1'($urandom), W'($urandom), modeTag(c, s));
    end
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule